// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe Sequencer

This block runs one DMA pipe. Software puts 8-byte descriptors into a circular ring in memory. It sets the ring's base address and its size in bytes. To post work, it writes the byte offset just past the last valid descriptor into a doorbell register. Whenever the pipe's own offset differs from the doorbell, the pipe reads the descriptor at that offset through a simple one-cycle read port. It passes the buffer request (address, byte count, direction, end-of-block and fence marks) to a downstream data mover over a valid/ready handshake. Then it advances its offset by 8, wrapping to zero at the ring size.

Flag bits in each descriptor select which completion events fire. The pipe also signals when it has run out of posted work. A control register enables the pipe and sets the transfer direction. A halt register pauses the walk at a descriptor boundary, and a pipe reset register holds the whole pipe at its defaults. The current offset is always visible on an output.

Top module: `dring_pipe_seq`

## Requirements
- R1: After reset, `cur_ofs` is 0 and `mem_rd_en`, `xfer_valid`, `ev_desc_done`, `ev_xfer_end` and `ev_no_desc` are all low.
- R2: The descriptor is read at byte address ring base + `cur_ofs`. In `mem_rd_data`, bits [31:0] hold the buffer address, bits [47:32] the byte count and bits [63:48] the flags. The request carries that address and byte count.
- R3: Register writes use `reg_addr` codes 0 = control, 1 = pipe reset, 2 = halt, 3 = doorbell, 4 = ring base, 5 = ring size (bytes). While `cur_ofs` differs from the doorbell, the pipe processes one descriptor at a time and adds 8 to `cur_ofs` after each one. It stops with `cur_ofs` equal to the doorbell.
- R4: When the advanced offset reaches or passes the ring size, `cur_ofs` becomes 0.
- R5: When a descriptor with flag bit 15 set completes, `ev_desc_done` pulses for one cycle.
- R6: When a descriptor with flag bit 14 set completes, `ev_xfer_end` pulses for one cycle. Flag bit 13 is presented as `xfer_eob` and flag bit 12 as `xfer_fence` with the request.
- R7: When a completion makes `cur_ofs` equal to the doorbell, `ev_no_desc` pulses in the same cycle as that descriptor's own events. The pipe then stays idle until the doorbell changes.
- R8: A descriptor with a byte count of 0 produces no request, but its flags still raise their events.
- R9: Control bit 1 enables the pipe; while it is 0, no descriptor is read. Control bit 3 sets `xfer_to_mem` (1 = peripheral to memory).
- R10: While halt bit 0 is 1, no new descriptor is started. Clearing it resumes from the same offset.
- R11: While `xfer_valid` is high and `xfer_ready` is low, the request stays up with stable fields. Each accepted handshake is exactly one transfer.
- R12: While pipe reset bit 0 is 1, every register and the offset go to their defaults: disabled, not halted, doorbell 0, base 0, ring size 64. Writing 0 releases the pipe.
- R13: `cur_ofs` is always a multiple of 8 and changes only when a descriptor completes or the pipe is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register code |
| reg_wdata | input | 32 | Register write data |
| cur_ofs | output | 16 | Current byte offset in the ring |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_data | input | 64 | Descriptor word, valid one cycle after the request |
| xfer_valid | output | 1 | Buffer request valid |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_addr | output | 32 | Buffer address |
| xfer_bytes | output | 16 | Buffer byte count |
| xfer_to_mem | output | 1 | 1 = peripheral to memory |
| xfer_eob | output | 1 | End-of-block mark |
| xfer_fence | output | 1 | Fence / no-write-done mark |
| ev_desc_done | output | 1 | Processed-descriptor event |
| ev_xfer_end | output | 1 | Transfer-end event |
| ev_no_desc | output | 1 | Out-of-descriptors event |

## Verification
The last posted descriptor can complete and empty the ring in one and the same cycle. So `ev_desc_done`, `ev_xfer_end` and `ev_no_desc` can all fire together. The bench provokes this by posting a run whose final descriptor carries the interrupt and end-of-transfer flags, then counts the cycles in which the events coincide. It expects exactly one such cycle, with the offset landing on the doorbell. A zero-length descriptor with an interrupt flag provokes the same overlap with no request in between.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_WAIT,
      WS_SEND,
      WS_DONE
   } walk_st_e;

   typedef struct packed {
      logic [15:0] flags;
      logic [15:0] bytes;
      logic [31:0] addr;
   } ring_desc_t;

   localparam int unsigned DESC_BYTES = 8;

   localparam int unsigned FLG_IRQ   = 15;
   localparam int unsigned FLG_EOT   = 14;
   localparam int unsigned FLG_EOB   = 13;
   localparam int unsigned FLG_FENCE = 12;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_PRST  = 3'd1;
   localparam logic [2:0] RA_HALT  = 3'd2;
   localparam logic [2:0] RA_BELL  = 3'd3;
   localparam logic [2:0] RA_BASE  = 3'd4;
   localparam logic [2:0] RA_SIZE  = 3'd5;

   localparam int unsigned CTL_EN  = 1;
   localparam int unsigned CTL_DIR = 3;

endpackage

// File: rtl/dps_regs.sv
module dps_regs
   import dps_pkg::*;
#(
   parameter int unsigned OFS_W          = 16,
   parameter int unsigned DEF_RING_BYTES = 64,
   localparam int unsigned SZ_W          = OFS_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       addr,
   input  logic [31:0]      wdata,
   output logic             srst,
   output logic             en,
   output logic             to_mem,
   output logic             halt,
   output logic [OFS_W-1:0] bell,
   output logic [31:0]      base,
   output logic [SZ_W-1:0]  rsize
);

   localparam logic [SZ_W-1:0] SIZE_RST = SZ_W'(DEF_RING_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst <= 1'b0;
      end else if (we && addr == RA_PRST) begin
         srst <= wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         to_mem <= 1'b0;
         halt   <= 1'b0;
         bell   <= '0;
         base   <= '0;
         rsize  <= SIZE_RST;
      end else if (srst) begin
         en     <= 1'b0;
         to_mem <= 1'b0;
         halt   <= 1'b0;
         bell   <= '0;
         base   <= '0;
         rsize  <= SIZE_RST;
      end else if (we) begin
         case (addr)
            RA_CTRL: begin
               en     <= wdata[CTL_EN];
               to_mem <= wdata[CTL_DIR];
            end
            RA_HALT: halt  <= wdata[0];
            RA_BELL: bell  <= wdata[OFS_W-1:0];
            RA_BASE: base  <= wdata;
            RA_SIZE: rsize <= wdata[SZ_W-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dps_step.sv
module dps_step
   import dps_pkg::*;
#(
   parameter int unsigned OFS_W = 16,
   localparam int unsigned SZ_W = OFS_W + 1
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic [SZ_W-1:0]  rsize,
   output logic [OFS_W-1:0] nxt
);

   logic [SZ_W-1:0] sum;

   always_comb begin
      sum = {1'b0, ofs} + SZ_W'(DESC_BYTES);
      nxt = (sum >= rsize) ? '0 : sum[OFS_W-1:0];
   end

endmodule

// File: rtl/dps_walker.sv
module dps_walker
   import dps_pkg::*;
#(
   parameter int unsigned OFS_W = 16,
   localparam int unsigned SZ_W = OFS_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             en,
   input  logic             halt,
   input  logic             to_mem,
   input  logic [OFS_W-1:0] bell,
   input  logic [31:0]      base,
   input  logic [SZ_W-1:0]  rsize,
   input  logic [63:0]      mem_rd_data,
   input  logic             xfer_ready,
   output logic             mem_rd_en,
   output logic [31:0]      mem_rd_addr,
   output logic             xfer_valid,
   output logic [31:0]      xfer_addr,
   output logic [15:0]      xfer_bytes,
   output logic             xfer_to_mem,
   output logic             xfer_eob,
   output logic             xfer_fence,
   output logic             ev_desc_done,
   output logic             ev_xfer_end,
   output logic             ev_no_desc,
   output logic [OFS_W-1:0] cur_ofs
);

   localparam int unsigned NUM_EV = 2;
   localparam logic [4*NUM_EV-1:0] EV_POS = {4'(FLG_EOT), 4'(FLG_IRQ)};

   walk_st_e        st_q;
   logic [OFS_W-1:0] ofs_q;
   logic [OFS_W-1:0] ofs_nxt;
   ring_desc_t      dsc_q;
   logic            dir_q;
   logic            go;
   logic            done;
   logic [NUM_EV-1:0] ev_vec;

   dps_step #(.OFS_W(OFS_W)) u_step (
      .ofs   (ofs_q),
      .rsize (rsize),
      .nxt   (ofs_nxt)
   );

   assign go   = en && !halt && (ofs_q != bell);
   assign done = (st_q == WS_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WS_IDLE;
         ofs_q <= '0;
         dsc_q <= '0;
         dir_q <= 1'b0;
      end else if (srst) begin
         st_q  <= WS_IDLE;
         ofs_q <= '0;
         dsc_q <= '0;
         dir_q <= 1'b0;
      end else begin
         case (st_q)
            WS_IDLE: if (go) st_q <= WS_WAIT;
            WS_WAIT: begin
               dsc_q <= ring_desc_t'(mem_rd_data);
               dir_q <= to_mem;
               st_q  <= (mem_rd_data[47:32] != 16'd0) ? WS_SEND : WS_DONE;
            end
            WS_SEND: if (xfer_ready) st_q <= WS_DONE;
            WS_DONE: begin
               ofs_q <= ofs_nxt;
               st_q  <= WS_IDLE;
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   generate
      for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_ev
         assign ev_vec[gi] = done && dsc_q.flags[EV_POS[gi*4 +: 4]];
      end
   endgenerate

   assign mem_rd_en    = (st_q == WS_IDLE) && go && !srst;
   assign mem_rd_addr  = base + 32'(ofs_q);
   assign xfer_valid   = (st_q == WS_SEND);
   assign xfer_addr    = dsc_q.addr;
   assign xfer_bytes   = dsc_q.bytes;
   assign xfer_to_mem  = dir_q;
   assign xfer_eob     = dsc_q.flags[FLG_EOB];
   assign xfer_fence   = dsc_q.flags[FLG_FENCE];
   assign ev_desc_done = ev_vec[0];
   assign ev_xfer_end  = ev_vec[1];
   assign ev_no_desc   = done && (ofs_nxt == bell);
   assign cur_ofs      = ofs_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || srst)
      xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_bytes)); // R11

   AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> xfer_bytes != 16'd0); // R8

   AST_OFS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_q[2:0] == 3'd0); // R13

   AST_OFS_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_q != $past(ofs_q)) |-> ($past(st_q) == WS_DONE || $past(srst))); // R13

endmodule

// File: rtl/dring_pipe_seq.sv
module dring_pipe_seq
   import dps_pkg::*;
#(
   parameter int unsigned OFS_W          = 16,
   parameter int unsigned DEF_RING_BYTES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [OFS_W-1:0] cur_ofs,
   output logic             mem_rd_en,
   output logic [31:0]      mem_rd_addr,
   input  logic [63:0]      mem_rd_data,
   output logic             xfer_valid,
   input  logic             xfer_ready,
   output logic [31:0]      xfer_addr,
   output logic [15:0]      xfer_bytes,
   output logic             xfer_to_mem,
   output logic             xfer_eob,
   output logic             xfer_fence,
   output logic             ev_desc_done,
   output logic             ev_xfer_end,
   output logic             ev_no_desc
);

   localparam int unsigned SZ_W = OFS_W + 1;

   generate
      if (OFS_W < 4 || OFS_W > 31) begin : g_bad_ofs
         $error("OFS_W out of range");
      end
      if (DEF_RING_BYTES % DESC_BYTES != 0 || DEF_RING_BYTES == 0 ||
          DEF_RING_BYTES > (1 << OFS_W)) begin : g_bad_ring
         $error("DEF_RING_BYTES must be a non-zero multiple of 8 within the offset range");
      end
   endgenerate

   logic             srst;
   logic             en;
   logic             to_mem;
   logic             halt;
   logic [OFS_W-1:0] bell;
   logic [31:0]      base;
   logic [SZ_W-1:0]  rsize;

   dps_regs #(.OFS_W(OFS_W), .DEF_RING_BYTES(DEF_RING_BYTES)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .srst   (srst),
      .en     (en),
      .to_mem (to_mem),
      .halt   (halt),
      .bell   (bell),
      .base   (base),
      .rsize  (rsize)
   );

   dps_walker #(.OFS_W(OFS_W)) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .srst         (srst),
      .en           (en),
      .halt         (halt),
      .to_mem       (to_mem),
      .bell         (bell),
      .base         (base),
      .rsize        (rsize),
      .mem_rd_data  (mem_rd_data),
      .xfer_ready   (xfer_ready),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_addr  (mem_rd_addr),
      .xfer_valid   (xfer_valid),
      .xfer_addr    (xfer_addr),
      .xfer_bytes   (xfer_bytes),
      .xfer_to_mem  (xfer_to_mem),
      .xfer_eob     (xfer_eob),
      .xfer_fence   (xfer_fence),
      .ev_desc_done (ev_desc_done),
      .ev_xfer_end  (ev_xfer_end),
      .ev_no_desc   (ev_no_desc),
      .cur_ofs      (cur_ofs)
   );

   AST_NO_READ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> en && !halt); // R9 R10

   AST_EMPTY_AT_BELL: assert property (@(posedge clk) disable iff (!rst_n || srst)
      ev_no_desc |=> cur_ofs == $past(bell)); // R7

   AST_PRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> cur_ofs == '0 && !xfer_valid); // R12

endmodule

// File: tb/dring_pipe_seq_tb_top.sv
module dring_pipe_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [15:0] cur_ofs;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [63:0] mem_rd_data = '0;
   logic        xfer_valid;
   logic        xfer_ready = 1'b1;
   logic [31:0] xfer_addr;
   logic [15:0] xfer_bytes;
   logic        xfer_to_mem;
   logic        xfer_eob;
   logic        xfer_fence;
   logic        ev_desc_done;
   logic        ev_xfer_end;
   logic        ev_no_desc;

   int vectors = 0;
   int misses  = 0;
   bit finished = 1'b0;

   logic [63:0] ring_mem [64];

   int n_req = 0, n_desc = 0, n_end = 0, n_nod = 0, n_both = 0, n_rd = 0, n_hold_err = 0;
   logic [31:0] rq_addr [64];
   logic [15:0] rq_bytes [64];
   logic        rq_dir [64];
   logic        rq_eob [64];
   logic        rq_fence [64];
   logic        stall_q = 1'b0;
   logic [31:0] stall_addr = '0;
   logic [15:0] stall_bytes = '0;

   always #10 clk = ~clk;

   dring_pipe_seq dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_we       (reg_we),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .cur_ofs      (cur_ofs),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_data  (mem_rd_data),
      .xfer_valid   (xfer_valid),
      .xfer_ready   (xfer_ready),
      .xfer_addr    (xfer_addr),
      .xfer_bytes   (xfer_bytes),
      .xfer_to_mem  (xfer_to_mem),
      .xfer_eob     (xfer_eob),
      .xfer_fence   (xfer_fence),
      .ev_desc_done (ev_desc_done),
      .ev_xfer_end  (ev_xfer_end),
      .ev_no_desc   (ev_no_desc)
   );

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= ring_mem[mem_rd_addr[8:3]];
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en) n_rd++;
         if (ev_desc_done) n_desc++;
         if (ev_xfer_end) n_end++;
         if (ev_no_desc) n_nod++;
         if (ev_no_desc && ev_desc_done) n_both++;
         if (stall_q && (!xfer_valid || xfer_addr != stall_addr || xfer_bytes != stall_bytes))
            n_hold_err++;
         if (xfer_valid && xfer_ready) begin
            rq_addr[n_req % 64]  = xfer_addr;
            rq_bytes[n_req % 64] = xfer_bytes;
            rq_dir[n_req % 64]   = xfer_to_mem;
            rq_eob[n_req % 64]   = xfer_eob;
            rq_fence[n_req % 64] = xfer_fence;
            n_req++;
         end
         stall_q     = xfer_valid && !xfer_ready;
         stall_addr  = xfer_addr;
         stall_bytes = xfer_bytes;
      end
   end

   function automatic logic [63:0] mk_desc(logic [31:0] a, logic [15:0] b, logic [15:0] f);
      return {f, b, a};
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(string req, longint act, longint exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk_eq("R1 cur_ofs", cur_ofs, 0);
      chk_eq("R1 quiet outputs", {mem_rd_en, xfer_valid, ev_desc_done, ev_xfer_end, ev_no_desc}, 0);
   endtask

   task automatic t_basic_walk;
      int r0 = n_req, d0 = n_desc, e0 = n_end, o0 = n_nod, b0 = n_both;
      ring_mem[32] = mk_desc(32'h1000, 16'd16, 16'h0000);
      ring_mem[33] = mk_desc(32'h2000, 16'd32, 16'h8000);
      ring_mem[34] = mk_desc(32'h3000, 16'd48, 16'hC000);
      wr(3'd4, 32'h100);
      wr(3'd5, 32'd64);
      wr(3'd0, 32'h0A);
      wr(3'd3, 32'd24);
      settle(40);
      chk_eq("R3 request count", n_req - r0, 3);
      chk_eq("R2 first addr", rq_addr[r0 % 64], 32'h1000);
      chk_eq("R2 first bytes", rq_bytes[r0 % 64], 16);
      chk_eq("R2 last addr", rq_addr[(r0 + 2) % 64], 32'h3000);
      chk_eq("R2 last bytes", rq_bytes[(r0 + 2) % 64], 48);
      chk_eq("R9 direction to memory", rq_dir[r0 % 64], 1);
      chk_eq("R3 stops at doorbell", cur_ofs, 24);
      chk_eq("R5 desc events", n_desc - d0, 2);
      chk_eq("R6 end events", n_end - e0, 1);
      chk_eq("R7 no-desc events", n_nod - o0, 1);
      chk_eq("R7 coincident with desc event", n_both - b0, 1);
      chk_eq("R13 aligned", cur_ofs[2:0], 0);
   endtask

   task automatic t_zero_and_marks;
      int r0 = n_req, d0 = n_desc, o0 = n_nod;
      ring_mem[35] = mk_desc(32'h4000, 16'd0, 16'h8000);
      wr(3'd3, 32'd32);
      settle(20);
      chk_eq("R8 zero count no request", n_req - r0, 0);
      chk_eq("R8 zero count flag honoured", n_desc - d0, 1);
      chk_eq("R8 offset advanced", cur_ofs, 32);
      chk_eq("R7 empty after zero desc", n_nod - o0, 1);
      ring_mem[36] = mk_desc(32'h5000, 16'd8, 16'h3000);
      wr(3'd3, 32'd40);
      settle(20);
      chk_eq("R6 eob mark", rq_eob[r0 % 64], 1);
      chk_eq("R6 fence mark", rq_fence[r0 % 64], 1);
   endtask

   task automatic t_wrap;
      int r0 = n_req;
      ring_mem[37] = mk_desc(32'h6000, 16'd4, 16'h0000);
      ring_mem[38] = mk_desc(32'h6100, 16'd4, 16'h0000);
      ring_mem[39] = mk_desc(32'h6200, 16'd4, 16'h0000);
      ring_mem[32] = mk_desc(32'h7000, 16'd4, 16'h0000);
      wr(3'd3, 32'd8);
      settle(50);
      chk_eq("R4 requests across wrap", n_req - r0, 4);
      chk_eq("R4 slot 0 after wrap", rq_addr[(r0 + 3) % 64], 32'h7000);
      chk_eq("R4 offset after wrap", cur_ofs, 8);
   endtask

   task automatic t_disabled;
      int rd0 = n_rd, r0;
      wr(3'd0, 32'h0);
      ring_mem[33] = mk_desc(32'h8000, 16'd4, 16'h0000);
      wr(3'd3, 32'd16);
      settle(20);
      chk_eq("R9 no read when disabled", n_rd - rd0, 0);
      chk_eq("R9 offset held when disabled", cur_ofs, 8);
      r0 = n_req;
      wr(3'd0, 32'h02);
      settle(20);
      chk_eq("R9 runs once enabled", rq_addr[r0 % 64], 32'h8000);
      chk_eq("R9 direction to peripheral", rq_dir[r0 % 64], 0);
      chk_eq("R9 offset after enable", cur_ofs, 16);
   endtask

   task automatic t_halt;
      int r0 = n_req;
      wr(3'd2, 32'h1);
      ring_mem[34] = mk_desc(32'h9000, 16'd4, 16'h0000);
      wr(3'd3, 32'd24);
      settle(20);
      chk_eq("R10 no request when halted", n_req - r0, 0);
      chk_eq("R10 offset held when halted", cur_ofs, 16);
      wr(3'd2, 32'h0);
      settle(20);
      chk_eq("R10 resumes same slot", rq_addr[r0 % 64], 32'h9000);
      chk_eq("R10 offset after resume", cur_ofs, 24);
   endtask

   task automatic t_backpressure;
      int r0 = n_req;
      @(negedge clk);
      xfer_ready = 1'b0;
      ring_mem[35] = mk_desc(32'hA000, 16'd12, 16'h0000);
      wr(3'd3, 32'd32);
      settle(20);
      chk_eq("R11 not accepted while stalled", n_req - r0, 0);
      chk_eq("R11 request held", xfer_valid, 1);
      chk_eq("R11 held address", xfer_addr, 32'hA000);
      xfer_ready = 1'b1;
      settle(20);
      chk_eq("R11 one transfer", n_req - r0, 1);
      chk_eq("R11 fields stable", n_hold_err, 0);
      chk_eq("R11 offset after accept", cur_ofs, 32);
   endtask

   task automatic t_pipe_reset;
      int rd0, r0;
      wr(3'd1, 32'h1);
      wr(3'd1, 32'h0);
      @(negedge clk);
      chk_eq("R12 offset cleared", cur_ofs, 0);
      rd0 = n_rd;
      wr(3'd3, 32'd8);
      settle(20);
      chk_eq("R12 control cleared", n_rd - rd0, 0);
      ring_mem[0] = mk_desc(32'hB000, 16'd4, 16'h0000);
      r0 = n_req;
      wr(3'd0, 32'h02);
      settle(20);
      chk_eq("R12 base back to 0", rq_addr[r0 % 64], 32'hB000);
      chk_eq("R12 offset after restart", cur_ofs, 8);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) ring_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic_walk();
      t_zero_and_marks();
      t_wrap();
      t_disabled();
      t_halt();
      t_backpressure();
      t_pipe_reset();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         vectors++;
         misses++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule